// File: doc/BRIEF.md
# Serial EEPROM Device Engine

This block is the device end of a byte-organised serial memory attached to an SPI bus. The pins are sampled by the system clock. The engine accepts commands in clock modes 0 and 3: it reads each bit on a rising serial clock and moves its output on a falling one. It decodes a one-byte opcode and, where the command needs one, a one-byte address. It then either streams bytes out or gathers up to one page of bytes to write.

The engine does not time or police nonvolatile writes itself. When a frame closes correctly, it pulses a request to a companion unit that owns write timing and protection. That unit reports back through a busy level and an apply strobe. The strobe moves the collected page into the 256-byte storage, which is modelled here as a register array. The protection level shown in the status byte is also supplied by the companion unit.

A pause input lets the host stop a transfer part-way through and resume it later without losing its place.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Opcode 0x05 streams a status byte, refreshed at every byte boundary, for as long as clocks continue, including while `wr_busy` is high. The status byte is `{4'b0000, prot_lvl[1:0], write_enable, wr_busy}`, with `wr_busy` in bit 0.
- R2: SI is captured on rising SCK and SO changes after falling SCK, MSB first. After reset `so_oe` is 0 and `wr_req` is 0.
- R3: Opcode 0x03 followed by an address streams bytes from that address upward. Each byte boundary advances the address, and 0xFF is followed by 0x00.
- R4: Opcode 0x02 followed by an address collects data bytes into a 4-byte page buffer. The offset within the page steps 3 to 0 without leaving the page, and a later byte overwrites an earlier one. The request reports `wr_page` as address bits [7:2], sets one `wr_mask` bit per written offset, and carries offset k in `wr_data[8k+7:8k]`.
- R5: A page write is requested only if chip select rises on a byte boundary after at least one data byte. A rise mid-byte, or a rise straight after the address, discards the frame.
- R6: Opcode 0x06 sets the write-enable flag only if chip select rises directly after its eighth bit. Any further clock edge in that frame cancels it. Opcode 0x04 clears the flag at once.
- R7: A write request is issued only while the write-enable flag is set, and issuing it clears the flag.
- R8: While `hold_n` is low, when taken low with SCK low, clock and data edges are ignored and `so_oe` is 0. Raising `hold_n` with SCK low resumes at the same bit.
- R9: After reset, no command is accepted until chip select has gone from high to low.
- R10: A frame whose first byte is not one of the six opcodes produces no output and no request until chip select rises.
- R11: While `wr_busy` is high, opcodes 0x03, 0x02 and 0x01 are ignored for the rest of the frame.
- R12: Opcode 0x01 takes one byte. It is requested as a status write (`wr_is_status` = 1, byte on `wr_status`) only if chip select rises directly after that byte.
- R13: A pulse on `wr_apply` writes the masked bytes of the last page request into storage, where they can be read back.
- R14: Commands behave the same whether SCK idles low (mode 0) or high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| prot_lvl | input | 2 | Protection level shown in the status byte |
| wr_busy | input | 1 | Companion unit is running a write cycle |
| wr_apply | input | 1 | One-cycle strobe that commits the pending page to storage |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO; 0 means high impedance |
| wr_req | output | 1 | One-cycle write request |
| wr_is_status | output | 1 | Request is a status write rather than a page write |
| wr_page | output | 6 | Page index of the pending page write |
| wr_data | output | 32 | Page buffer, offset k in bits 8k+7:8k |
| wr_mask | output | 4 | Offsets written in the page buffer |
| wr_status | output | 8 | Byte for a status write |

## Verification
The hardest case to reach is a pause that lands mid-byte while the engine is driving read data. By then a falling edge has already shifted out the next bit. Any SCK toggling during the pause must not move the shift registers, and the first bit after resume must be the one already waiting on SO. The stimulus pauses once inside the address byte and once inside a data byte, toggling SCK and SI while paused. It then checks that the address and the byte read back are the values expected with no pause at all. Write discarding is reached by ending frames three bits into a data byte and directly after the address, then confirming that no request appears.

// File: rtl/ee_pkg.sv
package ee_pkg;

  typedef enum logic [3:0] {
    ST_OPC,   // collecting the opcode
    ST_ADR,   // collecting the address
    ST_RD,    // streaming array bytes
    ST_WRD,   // collecting page bytes
    ST_SRO,   // streaming the status byte
    ST_SRI,   // collecting a status byte
    ST_SRW,   // status byte held, waiting for deselect
    ST_WEN,   // enable opcode held, waiting for deselect
    ST_SKIP   // frame ignored until deselect
  } ee_state_t;

  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_WDIS  = 8'h04;
  localparam logic [7:0] OP_RSTAT = 8'h05;
  localparam logic [7:0] OP_WSTAT = 8'h01;
  localparam logic [7:0] OP_RARR  = 8'h03;
  localparam logic [7:0] OP_WARR  = 8'h02;

  function automatic logic [7:0] stat_byte(logic [1:0] lvl, logic wel, logic busy);
    return {4'b0000, lvl, wel, busy};
  endfunction

endpackage

// File: rtl/ee_pin_front.sv
module ee_pin_front (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic sel,
  output logic rise,
  output logic fall,
  output logic cs_rise,
  output logic si_s,
  output logic paused
);
  logic cs_q, cs_q2, sck_q, sck_q2, hold_q, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      cs_q2  <= 1'b0;
      sck_q  <= 1'b0;
      sck_q2 <= 1'b0;
      si_s   <= 1'b0;
      hold_q <= 1'b1;
      armed  <= 1'b0;
      paused <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      cs_q2  <= cs_q;
      sck_q  <= sck;
      sck_q2 <= sck_q;
      si_s   <= si;
      hold_q <= hold_n;
      if (cs_q2 && !cs_q) armed <= 1'b1;
      // pause state only changes while the serial clock is low
      if (cs_q) paused <= 1'b0;
      else if (!sck_q) paused <= !hold_q;
    end
  end

  assign sel     = armed & ~cs_q;
  assign cs_rise = armed & cs_q & ~cs_q2;
  assign rise    = sel & ~paused & sck_q & ~sck_q2;
  assign fall    = sel & ~paused & ~sck_q & sck_q2;

endmodule

// File: rtl/ee_store.sv
module ee_store #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [7:0]                  rd_data,
  input  logic                        st_clr,
  input  logic                        st_we,
  input  logic [$clog2(PAGE_BYTES)-1:0] st_off,
  input  logic [7:0]                  st_byte,
  input  logic                        lock,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] lock_page,
  input  logic                        lock_arr,
  input  logic                        apply,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] pend_page,
  output logic [PAGE_BYTES*8-1:0]     pg_data,
  output logic [PAGE_BYTES-1:0]       pg_mask
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [7:0] mem   [DEPTH];
  logic [7:0] buf_q [PAGE_BYTES];
  logic       pend_arr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= 8'h00;
      pg_mask   <= '0;
      pend_page <= '0;
      pend_arr  <= 1'b0;
    end else begin
      if (st_clr) pg_mask <= '0;
      else if (st_we) begin
        buf_q[st_off]   <= st_byte;
        pg_mask[st_off] <= 1'b1;
      end
      if (lock) begin
        pend_page <= lock_page;
        pend_arr  <= lock_arr;
      end
      if (apply && pend_arr)
        for (int i = 0; i < PAGE_BYTES; i++)
          if (pg_mask[i]) mem[{pend_page, OFF_W'(i)}] <= buf_q[i];
    end
  end

  assign rd_data = mem[rd_addr];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_pack
    assign pg_data[g*8 +: 8] = buf_q[g];
  end

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import ee_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cs_n,
  input  logic                               sck,
  input  logic                               si,
  input  logic                               hold_n,
  input  logic [1:0]                         prot_lvl,
  input  logic                               wr_busy,
  input  logic                               wr_apply,
  output logic                               so,
  output logic                               so_oe,
  output logic                               wr_req,
  output logic                               wr_is_status,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] wr_page,
  output logic [PAGE_BYTES*8-1:0]            wr_data,
  output logic [PAGE_BYTES-1:0]              wr_mask,
  output logic [7:0]                         wr_status
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  function automatic logic [ADDR_W-1:0] page_step(logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], a[OFF_W-1:0] + OFF_W'(1)};
  endfunction

  logic sel, rise, fall, cs_rise, si_s, paused;

  ee_pin_front u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .sel(sel), .rise(rise), .fall(fall), .cs_rise(cs_rise), .si_s(si_s), .paused(paused)
  );

  ee_state_t         st;
  logic [2:0]        bit_cnt;
  logic [6:0]        sh_in;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        out_sh;
  logic              so_q, drv, wel, is_rd;
  logic [7:0]        sr_val;

  logic [7:0]        byte_in, status_now, rd_data;
  logic              byte_done, commit_arr, commit_sr, wren_hit, wdis_hit;
  logic [ADDR_W-1:0] rd_addr;

  assign byte_in    = {sh_in, si_s};
  assign byte_done  = rise && (bit_cnt == 3'd7);
  assign status_now = stat_byte(prot_lvl, wel, wr_busy);
  assign rd_addr    = (st == ST_ADR) ? byte_in[ADDR_W-1:0] : addr + ADDR_W'(1);

  assign commit_arr = cs_rise && st == ST_WRD && bit_cnt == 3'd0 && (|wr_mask) && wel && !wr_busy;
  assign commit_sr  = cs_rise && st == ST_SRW && wel && !wr_busy;
  assign wren_hit   = cs_rise && st == ST_WEN;
  assign wdis_hit   = byte_done && st == ST_OPC && byte_in == OP_WDIS;

  ee_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .st_clr(byte_done && st == ST_ADR && !is_rd),
    .st_we(byte_done && st == ST_WRD),
    .st_off(addr[OFF_W-1:0]), .st_byte(byte_in),
    .lock(commit_arr | commit_sr), .lock_page(addr[ADDR_W-1:OFF_W]), .lock_arr(commit_arr),
    .apply(wr_apply), .pend_page(wr_page), .pg_data(wr_data), .pg_mask(wr_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OPC; bit_cnt <= 3'd0; sh_in <= '0; addr <= '0;
      out_sh <= 8'h00; so_q <= 1'b0; drv <= 1'b0; wel <= 1'b0; is_rd <= 1'b0;
      sr_val <= 8'h00; wr_req <= 1'b0; wr_is_status <= 1'b0;
    end else begin
      wr_req <= commit_arr | commit_sr;
      if (commit_arr | commit_sr) wr_is_status <= commit_sr;
      if (commit_arr | commit_sr) wel <= 1'b0;
      else if (wren_hit)          wel <= 1'b1;
      else if (wdis_hit)          wel <= 1'b0;

      if (!sel) begin
        st <= ST_OPC; bit_cnt <= 3'd0; drv <= 1'b0;
      end else begin
        if (rise) begin
          sh_in   <= byte_in[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (fall && (st == ST_RD || st == ST_SRO)) begin
          so_q   <= out_sh[7];
          out_sh <= {out_sh[6:0], 1'b0};
          drv    <= 1'b1;
        end
        if (rise && (st == ST_WEN || st == ST_SRW)) st <= ST_SKIP;
        if (byte_done) begin
          case (st)
            ST_OPC: begin
              case (byte_in)
                OP_WEN:   st <= ST_WEN;
                OP_RSTAT: begin st <= ST_SRO; out_sh <= status_now; end
                OP_WSTAT: st <= wr_busy ? ST_SKIP : ST_SRI;
                OP_RARR:  begin st <= wr_busy ? ST_SKIP : ST_ADR; is_rd <= 1'b1; end
                OP_WARR:  begin st <= wr_busy ? ST_SKIP : ST_ADR; is_rd <= 1'b0; end
                default:  st <= ST_SKIP;
              endcase
            end
            ST_ADR: begin
              addr <= byte_in[ADDR_W-1:0];
              if (is_rd) begin out_sh <= rd_data; st <= ST_RD; end
              else st <= ST_WRD;
            end
            ST_RD:  begin addr <= addr + ADDR_W'(1); out_sh <= rd_data; end
            ST_WRD: addr <= page_step(addr);
            ST_SRO: out_sh <= status_now;
            ST_SRI: begin sr_val <= byte_in; st <= ST_SRW; end
            default: ;
          endcase
        end
      end
    end
  end

  assign so        = so_q;
  assign so_oe     = sel & ~paused & drv;
  assign wr_status = sr_val;

  p_req_consumes_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> ($past(wel) && !wel));
  p_req_unit_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !$past(wr_busy));
  p_req_at_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> $past(cs_rise));
  p_pause_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && sel) |=> ($stable(bit_cnt) && $stable(sh_in)));
  p_wel_after_wren_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> ($past(cs_rise) && $past(st) == ST_WEN));
  p_page_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_is_status) |-> (wr_mask != '0));

endmodule

// File: tb/spi_eeprom_slave_tb_top.sv
module spi_eeprom_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n, cs_n, sck, si, hold_n;
  logic [1:0] bp;
  logic wr_busy, wr_apply;
  logic so, so_oe, wr_req, wr_is_status;
  logic [5:0] wr_page;
  logic [31:0] wr_data;
  logic [3:0] wr_mask;
  logic [7:0] wr_status;

  always #10 clk = ~clk;

  spi_eeprom_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .prot_lvl(bp), .wr_busy(wr_busy), .wr_apply(wr_apply),
    .so(so), .so_oe(so_oe), .wr_req(wr_req), .wr_is_status(wr_is_status),
    .wr_page(wr_page), .wr_data(wr_data), .wr_mask(wr_mask), .wr_status(wr_status)
  );

  int n_cmp = 0, n_bad = 0, req_count = 0, busy_cnt = 0;
  logic mode3 = 1'b0, oe_seen;
  logic last_st; logic [5:0] last_page; logic [31:0] last_data;
  logic [3:0] last_mask; logic [7:0] last_sr;

  // companion write-timing unit model
  always @(posedge clk) begin
    if (!rst_n) begin
      wr_busy <= 1'b0; wr_apply <= 1'b0; busy_cnt <= 0;
    end else begin
      wr_apply <= 1'b0;
      if (wr_req) begin
        req_count <= req_count + 1;
        last_st <= wr_is_status; last_page <= wr_page; last_data <= wr_data;
        last_mask <= wr_mask; last_sr <= wr_status;
        busy_cnt <= 400; wr_busy <= 1'b1;
      end else if (busy_cnt != 0) begin
        busy_cnt <= busy_cnt - 1;
        if (busy_cnt == 1) begin
          wr_apply <= 1'b1; wr_busy <= 1'b0;
          if (last_st) bp <= last_sr[3:2];
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] rx_val;
  event rx_ev;
  initial forever begin
    @(rx_ev);
    if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
    else chk(tag_q.pop_front(), {24'h0, rx_val}, {24'h0, exp_q.pop_front()});
  end

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r);
    sck = 1'b0; si = b; half();
    r = so; oe_seen = oe_seen | so_oe;
    sck = 1'b1; half();
  endtask

  task automatic spi_xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      spi_bit(tx[i], b);
      rx[i] = b;
    end
  endtask

  task automatic tx(input logic [7:0] v);
    logic [7:0] r;
    spi_xfer(v, r);
  endtask

  task automatic rd_byte(string tag, logic [7:0] exp);
    logic [7:0] r;
    exp_q.push_back(exp); tag_q.push_back(tag);
    spi_xfer(8'h00, r);
    rx_val = r; -> rx_ev;
  endtask

  task automatic cs_on();
    sck = mode3; si = 1'b0; half();
    cs_n = 1'b0; half();
  endtask

  task automatic cs_off();
    if (!mode3) begin sck = 1'b0; half(); end
    cs_n = 1'b1; half(); half();
  endtask

  task automatic cmd(input logic [7:0] op);
    cs_on(); tx(op); cs_off();
  endtask

  task automatic rdsr(string tag, logic [7:0] exp);
    cs_on(); tx(8'h05); rd_byte(tag, exp); cs_off();
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (wr_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic paused_toggles(string tag);
    hold_n = 1'b0; half();
    for (int k = 0; k < 3; k++) begin
      si = 1'b1; sck = 1'b1; half(); sck = 1'b0; half();
    end
    chk(tag, so_oe, 0);
    hold_n = 1'b1; half();
  endtask

  initial begin
    logic [7:0] r;
    int n0;
    logic b;
    cs_n = 1'b0; sck = 1'b0; si = 1'b0; hold_n = 1'b1; bp = 2'b10; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 reset so_oe", so_oe, 0);
    chk("R2 reset wr_req", wr_req, 0);

    // R9: select held low through reset, so no command is accepted
    oe_seen = 1'b0; tx(8'h05); tx(8'h00);
    chk("R9 no output before first select", oe_seen, 0);
    cs_n = 1'b1; half(); half();

    // R1: status streams repeatedly
    cs_on(); tx(8'h05); rd_byte("R1 status", 8'h08); rd_byte("R1 status repeat", 8'h08); cs_off();

    // R6: enable and disable
    cmd(8'h06); rdsr("R6 enable set", 8'h0A);
    cmd(8'h04); rdsr("R6 disable clears", 8'h08);
    cs_on(); tx(8'h06); spi_bit(1'b0, b); cs_off();
    rdsr("R6 trailing clock cancels enable", 8'h08);

    // R10: unknown opcode
    cs_on(); oe_seen = 1'b0; tx(8'hFF); tx(8'h05); tx(8'h00); cs_off();
    chk("R10 unknown opcode silent", oe_seen, 0);

    // R4: page write with wrap inside the page
    cmd(8'h06); n0 = req_count;
    cs_on(); tx(8'h02); tx(8'h41); tx(8'h11); tx(8'h22); tx(8'h33); tx(8'h44); cs_off();
    chk("R4 request issued", req_count, n0 + 1);
    chk("R4 page write kind", last_st, 0);
    chk("R4 page index", last_page, 6'h10);
    chk("R4 mask", last_mask, 4'hF);
    chk("R4 wrapped data", last_data, 32'h33221144);

    // R11 and R7: busy, enable consumed; status still readable
    rdsr("R11 status while busy", 8'h09);
    cs_on(); oe_seen = 1'b0; tx(8'h03); tx(8'h40); tx(8'h00); cs_off();
    chk("R11 read ignored while busy", oe_seen, 0);
    wait_idle();

    // R13 / R3: read back, address increments
    cs_on(); tx(8'h03); tx(8'h40);
    rd_byte("R13 applied byte", 8'h44); rd_byte("R13 applied byte", 8'h11);
    rd_byte("R3 increment", 8'h22); rd_byte("R3 increment", 8'h33); rd_byte("R3 next page", 8'h00);
    cs_off();

    // R3: wrap from the top of the array
    cmd(8'h06); cs_on(); tx(8'h02); tx(8'hFF); tx(8'h5A); cs_off();
    chk("R4 single byte mask", last_mask, 4'h8);
    chk("R4 top page index", last_page, 6'h3F);
    wait_idle();
    cmd(8'h06); cs_on(); tx(8'h02); tx(8'h00); tx(8'hA5); cs_off();
    wait_idle();
    cs_on(); tx(8'h03); tx(8'hFF);
    rd_byte("R3 last address", 8'h5A); rd_byte("R3 wrap to zero", 8'hA5); rd_byte("R3 after wrap", 8'h00);
    cs_off();

    // R5: discarded writes
    cmd(8'h06); n0 = req_count;
    cs_on(); tx(8'h02); tx(8'h10); tx(8'h77);
    spi_bit(1'b1, b); spi_bit(1'b0, b); spi_bit(1'b1, b); cs_off();
    chk("R5 mid-byte deselect discards", req_count, n0);
    rdsr("R5 enable kept after discard", 8'h0A);
    cs_on(); tx(8'h02); tx(8'h10); cs_off();
    chk("R5 no data bytes discards", req_count, n0);
    // R7: write without enable
    cmd(8'h04);
    cs_on(); tx(8'h02); tx(8'h10); tx(8'h77); cs_off();
    chk("R7 no request without enable", req_count, n0);
    cs_on(); tx(8'h03); tx(8'h10); rd_byte("R5 storage untouched", 8'h00); cs_off();

    // R8: pause inside the address and inside a data byte
    cs_on(); tx(8'h03);
    spi_bit(1'b0, b); spi_bit(1'b1, b); spi_bit(1'b0, b); spi_bit(1'b0, b);
    sck = 1'b0; half();
    paused_toggles("R8 paused in address");
    spi_bit(1'b0, b); spi_bit(1'b0, b); spi_bit(1'b0, b); spi_bit(1'b1, b);
    for (int i = 7; i >= 4; i--) begin spi_bit(1'b0, b); r[i] = b; end
    sck = 1'b0; half();
    paused_toggles("R8 paused in data");
    for (int i = 3; i >= 0; i--) begin spi_bit(1'b0, b); r[i] = b; end
    exp_q.push_back(8'h11); tag_q.push_back("R8 resume in place");
    rx_val = r; -> rx_ev;
    rd_byte("R8 following byte", 8'h22);
    cs_off();

    // R14: mode 3
    mode3 = 1'b1; sck = 1'b1; half();
    cs_on(); tx(8'h03); tx(8'h41);
    rd_byte("R14 mode3 read", 8'h11); rd_byte("R14 mode3 read", 8'h22); rd_byte("R14 mode3 read", 8'h33);
    cs_off();
    rdsr("R14 mode3 status", 8'h08);
    mode3 = 1'b0; sck = 1'b0; half();

    // R12: status write
    cmd(8'h06); n0 = req_count;
    cs_on(); tx(8'h01); tx(8'h04); cs_off();
    chk("R12 request issued", req_count, n0 + 1);
    chk("R12 status kind", last_st, 1);
    chk("R12 status byte", last_sr, 8'h04);
    wait_idle();
    rdsr("R12 new level shown", 8'h04);

    half();
    chk("scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule